// File: doc/BRIEF.md
# DDR Slow-Clock Phase Locator

This block finds where a slow reference clock sits inside the period of a fast clock that runs 3.5 times faster. A 7-bit double-data-rate deserializer can then tell which of its seven half-cycle data slots begins each word. The slow domain keeps a register that flips on every slow rising edge. The fast domain captures that toggle twice, once on each fast edge. Whenever the two captures disagree, the slow edge has just been crossed.

Each slow edge makes exactly one strobe. The strobe comes from the rising-edge lane when the falling edge saw the toggle change first, and from the falling-edge lane otherwise. With a ratio of 3.5:1 this ownership alternates from one slow period to the next. A 3-bit slot index counts one step per fast half-cycle. It is pulled to slot 3 when a strobe starts, so that every strobe covers slots 3 and 4. A lock flag reports that the alternation has been steady for several slow periods.

The slow clock must be placed so that its rising edges never coincide with a fast edge. The usual choice is a quarter of a fast period away.

Top module: `ddr_phase_locator`

## Requirements
- R1: While `rst` is high, `strobe_rise`, `strobe_fall` and `locked` are 0 and `slot` is 0.
- R2: `slot` advances by one at every fast clock transition, rising or falling, and wraps from 6 to 0. At the first fast transition after reset it reads 1.
- R3: In the half-cycle in which a strobe rises, `slot` reads 3. In the following half-cycle it reads 4.
- R4: Each strobe is high for exactly one fast clock period, that is two half-cycles. It is launched from the edge of its own lane.
- R5: Each slow rising edge makes at most one strobe. Slow edges number j, counted from reset. Even-numbered edges produce `strobe_rise` and odd-numbered edges produce `strobe_fall`, so the two never overlap.
- R6: For the slow edge that falls between fast transitions t and t+1, the strobe rises at fast transition t+2. Transitions are counted from 0, the first rising edge after reset.
- R7: The first two toggle transitions after reset make no strobe. The third one makes the first strobe.
- R8: `locked` rises on the fourth strobe of an unbroken run in which each strobe comes from the opposite lane to the one before it.
- R9: `locked` falls after five fast rising edges pass with no strobe, or when two strobes in a row come from the same lane.
- R10: While the slow clock is stopped, no strobe appears and `slot` keeps counting. Once the slow clock resumes, strobes return and the lock is regained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow reference clock |
| clk_fast | input | 1 | Fast clock at 3.5 times the slow rate; both of its edges are used |
| rst | input | 1 | Asynchronous active-high reset for both domains |
| strobe_rise | output | 1 | Strobe launched from the fast rising edge |
| strobe_fall | output | 1 | Strobe launched from the fast falling edge |
| slot | output | 3 | Index of the current half-cycle data slot, 0 to 6 |
| locked | output | 1 | Strobe alternation has been steady |

## Verification
A slow edge placed between fast transitions t and t+1 shows up as a strobe at transition t+2, and the strobe falls at t+4. The slot index changes at every fast transition. The lock flag changes on a fast rising edge: the fourth alternating strobe sets it, and it clears ten half-cycles after the last strobe seen. The bench counts fast transitions from reset and samples a few time units after each one. It recomputes every output arithmetically from that count, including across a window in which the slow clock is held low, so each comparison falls inside the half-cycle where the result is due.

// File: rtl/ddr_phase_pkg.sv
package ddr_phase_pkg;
  localparam int SLOTS      = 7;
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int FORCE_SLOT = 3;

  typedef logic [SLOT_W-1:0] slot_t;

  function automatic slot_t slot_inc(slot_t s);
    return (s == slot_t'(SLOTS - 1)) ? '0 : s + slot_t'(1);
  endfunction
endpackage

// File: rtl/ddr_lane.sv
module ddr_lane
  import ddr_phase_pkg::*;
#(
  parameter bit ON_FALL   = 1'b0,
  parameter int ARM_TRANS = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  tog_in,
  input  logic  peer_tog,
  input  slot_t peer_slot,
  output logic  tog_q,
  output logic  strobe_q,
  output slot_t slot_q,
  output logic  edge_q
);
  localparam int AW = $clog2(ARM_TRANS + 1);

  logic          tog_q2;
  logic [AW-1:0] arm_cnt;
  logic          diff;
  logic          seen_trans;
  logic          armed;
  logic [AW-1:0] arm_cnt_nx;
  logic          strobe_nx;
  slot_t         slot_nx;

  always_comb begin
    diff       = tog_q ^ peer_tog;
    seen_trans = tog_q ^ tog_q2;
    armed      = (arm_cnt == AW'(ARM_TRANS));
    arm_cnt_nx = (seen_trans && !armed) ? arm_cnt + AW'(1) : arm_cnt;
    strobe_nx  = diff & armed;
    slot_nx    = diff ? slot_t'(FORCE_SLOT) : slot_inc(peer_slot);
  end

  generate
    if (ON_FALL) begin : g_fall
      always_ff @(negedge clk or posedge rst) begin
        if (rst) begin
          tog_q    <= 1'b0;
          tog_q2   <= 1'b0;
          arm_cnt  <= '0;
          strobe_q <= 1'b0;
          slot_q   <= '0;
          edge_q   <= 1'b0;
        end else begin
          tog_q    <= tog_in;
          tog_q2   <= tog_q;
          arm_cnt  <= arm_cnt_nx;
          strobe_q <= strobe_nx;
          slot_q   <= slot_nx;
          edge_q   <= ~edge_q;
        end
      end

      // R4: a falling-lane strobe lasts one fast period
      a_r4_fall_width: assert property (@(negedge clk) disable iff (rst)
        strobe_q |=> !strobe_q);
      // R3: the falling-lane slot reads 3 while its strobe is fresh
      a_r3_fall_slot: assert property (@(negedge clk) disable iff (rst)
        strobe_q |-> (slot_q == slot_t'(FORCE_SLOT)));
    end else begin : g_rise
      always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
          tog_q    <= 1'b0;
          tog_q2   <= 1'b0;
          arm_cnt  <= '0;
          strobe_q <= 1'b0;
          slot_q   <= '0;
          edge_q   <= 1'b0;
        end else begin
          tog_q    <= tog_in;
          tog_q2   <= tog_q;
          arm_cnt  <= arm_cnt_nx;
          strobe_q <= strobe_nx;
          slot_q   <= slot_nx;
          edge_q   <= ~edge_q;
        end
      end

      // R4: a rising-lane strobe lasts one fast period
      a_r4_rise_width: assert property (@(posedge clk) disable iff (rst)
        strobe_q |=> !strobe_q);
      // R3: the rising-lane slot reads 3 while its strobe is fresh
      a_r3_rise_slot: assert property (@(posedge clk) disable iff (rst)
        strobe_q |-> (slot_q == slot_t'(FORCE_SLOT)));
    end
  endgenerate
endmodule

// File: rtl/lock_monitor.sv
module lock_monitor #(
  parameter int LOCK_RUN  = 4,
  parameter int GAP_LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ev_r,
  input  logic ev_f,
  output logic locked
);
  localparam int RW = $clog2(LOCK_RUN + 1);
  localparam int GW = $clog2(GAP_LIMIT + 1);

  logic          ev;
  logic          have_last;
  logic          last_r;
  logic [GW-1:0] gap;
  logic [RW-1:0] run;

  assign ev     = ev_r | ev_f;
  assign locked = (run == RW'(LOCK_RUN));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      have_last <= 1'b0;
      last_r    <= 1'b0;
      gap       <= '0;
      run       <= '0;
    end else if (ev) begin
      gap       <= '0;
      have_last <= 1'b1;
      last_r    <= ev_r;
      if (!have_last || (ev_r == last_r)) run <= RW'(1);
      else if (!locked)                   run <= run + RW'(1);
    end else if (gap == GW'(GAP_LIMIT)) begin
      have_last <= 1'b0;
      run       <= '0;
    end else begin
      gap <= gap + GW'(1);
    end
  end

  // R8: the flag only rises after a strobe was seen
  a_r8_rise_on_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(ev));
  // R9: a repeated lane breaks the lock
  a_r9_same_lane_drops: assert property (@(posedge clk) disable iff (rst)
    (have_last && ev && (ev_r == last_r)) |=> !locked);
endmodule

// File: rtl/ddr_phase_locator.sv
module ddr_phase_locator
  import ddr_phase_pkg::*;
#(
  parameter int ARM_TRANS = 2,
  parameter int LOCK_RUN  = 4
) (
  input  logic              clk_slow,
  input  logic              clk_fast,
  input  logic              rst,
  output logic              strobe_rise,
  output logic              strobe_fall,
  output logic [SLOT_W-1:0] slot,
  output logic              locked
);
  localparam int GAP_LIMIT = (SLOTS + 1) / 2;

  logic  tog;
  logic  tog_r, tog_f;
  logic  edge_r, edge_f;
  slot_t slot_r, slot_f;

  always_ff @(posedge clk_slow or posedge rst) begin
    if (rst) tog <= 1'b0;
    else     tog <= ~tog;
  end

  ddr_lane #(.ON_FALL(1'b0), .ARM_TRANS(ARM_TRANS)) u_rise (
    .clk(clk_fast), .rst(rst), .tog_in(tog), .peer_tog(tog_f), .peer_slot(slot_f),
    .tog_q(tog_r), .strobe_q(strobe_rise), .slot_q(slot_r), .edge_q(edge_r)
  );

  ddr_lane #(.ON_FALL(1'b1), .ARM_TRANS(ARM_TRANS)) u_fall (
    .clk(clk_fast), .rst(rst), .tog_in(tog), .peer_tog(tog_r), .peer_slot(slot_r),
    .tog_q(tog_f), .strobe_q(strobe_fall), .slot_q(slot_f), .edge_q(edge_f)
  );

  // the lane that toggled its edge flag last owns the current half-cycle
  assign slot = (edge_r ^ edge_f) ? slot_r : slot_f;

  lock_monitor #(.LOCK_RUN(LOCK_RUN), .GAP_LIMIT(GAP_LIMIT)) u_lock (
    .clk(clk_fast), .rst(rst), .ev_r(strobe_rise), .ev_f(strobe_fall), .locked(locked)
  );

  // R5: the two lanes never strobe together
  a_r5_lanes_exclusive: assert property (@(posedge clk_fast) disable iff (rst)
    !(strobe_rise && strobe_fall));
  // R2: the slot index stays within 0..6
  a_r2_slot_range: assert property (@(posedge clk_fast) disable iff (rst)
    slot <= SLOT_W'(SLOTS - 1));
endmodule

// File: tb/sim_ddr_phase_locator.sv
module sim_ddr_phase_locator;
  import ddr_phase_pkg::*;

  localparam int FAST_PERIOD = 20;
  localparam int HALF        = FAST_PERIOD / 2;
  localparam int SLOW_HALF   = FAST_PERIOD * 7 / 4;
  localparam int SLOW_OFS    = FAST_PERIOD / 4;
  localparam int SAMPLE_DLY  = 3;
  localparam int HOLD_FROM   = 40;
  localparam int HOLD_TO     = 50;
  localparam int LAST_H      = 450;
  // lock points in half-cycle counts, derived from R6, R8 and R9
  localparam int LOCK_ON  = 7 * 5 + 3;
  localparam int LOCK_OFF = 7 * (HOLD_FROM - 1) + 3 + 2 * 5;
  localparam int RELOCK   = 7 * (HOLD_TO + 3) + 3;

  logic clk_slow = 1'b0;
  logic clk_fast = 1'b0;
  logic rst      = 1'b1;
  logic run      = 1'b0;
  logic strobe_rise, strobe_fall, locked;
  logic [SLOT_W-1:0] slot;
  int   n_checks = 0;
  int   n_err    = 0;
  bit   done     = 1'b0;
  int   sj;

  ddr_phase_locator u0 (
    .clk_slow(clk_slow), .clk_fast(clk_fast), .rst(rst),
    .strobe_rise(strobe_rise), .strobe_fall(strobe_fall), .slot(slot), .locked(locked)
  );

  initial begin
    wait (run);
    #HALF;
    forever begin
      clk_fast = 1'b1; #HALF;
      clk_fast = 1'b0; #HALF;
    end
  end

  initial begin
    sj = 0;
    wait (run);
    #(HALF + SLOW_OFS);
    forever begin
      if (!(sj >= HOLD_FROM && sj < HOLD_TO)) clk_slow = 1'b1;
      #SLOW_HALF;
      clk_slow = 1'b0;
      #SLOW_HALF;
      sj++;
    end
  end

  task automatic check(string tag, string what, int h, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s at h=%0d: actual %0d expected %0d", tag, what, h, act, exp);
    end
  endtask

  function automatic bit edge_on(int j);
    return !(j >= HOLD_FROM && j < HOLD_TO);
  endfunction

  function automatic bit exp_strobe(int h, int parity);
    int r;
    int j;
    if (h < 2) return 1'b0;
    r = (h - 2) % 7;
    j = (h - 2) / 7;
    return (r <= 1) && (j >= 2) && ((j % 2) == parity) && edge_on(j);
  endfunction

  function automatic string strobe_tag(int h);
    int r;
    int j;
    if (h < 2) return "R5";
    r = (h - 2) % 7;
    j = (h - 2) / 7;
    if (!edge_on(j)) return "R10";
    if (j < 2)       return "R7";
    if (r == 0)      return "R6";
    if (r == 1)      return "R4";
    return "R5";
  endfunction

  function automatic string slot_tag(int h);
    int r;
    r = (h + 7 - 2) % 7;
    if (h >= 2 && r <= 1)                          return "R3";
    if (h >= 7 * HOLD_FROM && h < 7 * HOLD_TO)     return "R10";
    return "R2";
  endfunction

  initial begin
    #(FAST_PERIOD * 20000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    #7;
    check("R1", "strobe_rise in reset", -1, 8'(strobe_rise), 8'd0);
    check("R1", "strobe_fall in reset", -1, 8'(strobe_fall), 8'd0);
    check("R1", "slot in reset",        -1, 8'(slot),        8'd0);
    check("R1", "locked in reset",      -1, 8'(locked),      8'd0);
    #20;
    rst = 1'b0;
    #3;
    run = 1'b1;
    for (int h = 0; h <= LAST_H; h++) begin
      @(clk_fast);
      #SAMPLE_DLY;
      check(slot_tag(h), "slot", h, 8'(slot), 8'((h + 1) % 7));
      check(strobe_tag(h), "strobe_rise", h, 8'(strobe_rise), 8'(exp_strobe(h, 0)));
      check(strobe_tag(h), "strobe_fall", h, 8'(strobe_fall), 8'(exp_strobe(h, 1)));
      if (h < LOCK_OFF)
        check("R8", "locked", h, 8'(locked), 8'((h >= LOCK_ON) ? 1 : 0));
      else
        check("R9", "locked", h, 8'(locked), 8'((h >= RELOCK) ? 1 : 0));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule